// File: doc/BRIEF.md
# Write Data Latch and RAM Strobe Sequencer

This block sits between a processor bus that is paced by a slow enable phase (E, nominally 1.25 MHz) and a static RAM sharing a buffered data bus. Everything runs on one fast system clock. E, R/W and the processor byte arrive as plain levels synchronous to that clock. They pass through a configurable input register stage, and the E edges are found by comparing successive samples, so E is never used as a clock.

During a write (R/W low) the block drives a latched copy of the processor byte onto the shared bus. The copy follows the processor data while E is high and is frozen by the sample taken when E is first seen low. After R/W returns high, the bus keeps being driven with the frozen byte until the next rising edge of E, half an E period later. This satisfies the RAM data hold time, and the bus is released after it. An active-low RAM write strobe is produced only while E is high and R/W is low. Because E is high only once the address has settled, a write cannot land on a wrong location.

All outputs are registered. With the default single input stage, a change on an input shows at the outputs after two clock edges.

Top module: `bus_wr_latch`

## Requirements
- R1: While reset is held and after it, until the first write, `bus_oe` is 0, `ram_we_n` is 1 and `bus_data` is 0.
- R2: `ram_we_n` is 0 exactly when E is 1 and R/W is 0, delayed by IN_STAGES+1 clock cycles (two with defaults). It returns to 1 the same number of cycles after E falls.
- R3: A cycle with R/W held at 1 throughout never asserts `bus_oe` and never drives `ram_we_n` low.
- R4: After a write, `bus_data` equals the processor byte present in the clock cycle where E was first presented low.
- R5: `bus_oe` becomes 1 two cycles after R/W is presented low, and stays 1 while R/W stays low.
- R6: After R/W returns to 1, `bus_oe` stays 1 until the first E rising edge. It is still 1 one cycle after that edge is presented and 0 two cycles after it.
- R7: Processor data changes made after the capturing E falling edge do not reach `bus_data` during the hold interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than E |
| rst | input | 1 | Synchronous active-high reset |
| e_in | input | 1 | Bus enable phase level, synchronous to clk |
| rw_n | input | 1 | 1 = read, 0 = write |
| cpu_data | input | DATA_W | Processor write byte |
| bus_data | output | DATA_W | Latched byte for the shared data bus |
| bus_oe | output | 1 | Drive enable for `bus_data` (0 = high impedance) |
| ram_we_n | output | 1 | Active-low RAM write strobe |

## Verification
The properties assume that E and R/W are synchronous to the clock and that each E phase lasts at least two clock cycles. They also assume that R/W changes only while E is low or in the same cycle that E falls, so that no E rise is mistaken for the end of a hold interval. The stimulus draws every E phase length from a range whose minimum is two cycles for the high phase and three for the low phase. It lowers R/W at the start of a low phase and raises it together with the falling edge of E. Processor data is held for one cycle past that edge and then scrambled, so that a late capture would show on the bus.

// File: rtl/wl_pkg.sv
package wl_pkg;
  localparam logic RW_READ  = 1'b1;
  localparam logic RW_WRITE = 1'b0;

  typedef struct packed {
    logic e;
    logic rw_n;
  } wl_ctl_t;
endpackage

// File: rtl/wl_in_sync.sv
module wl_in_sync #(
  parameter int W = 10,
  parameter int STAGES = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) r <= RST_VAL;
        else     r <= g_stg[i-1].r;
      end
    end
  end

  assign q_out = g_stg[STAGES-1].r;
endmodule

// File: rtl/wl_seq.sv
module wl_seq (
  input  logic clk,
  input  logic rst,
  input  logic e_s,
  input  logic rw_s,
  output logic rise_e,
  output logic fall_e,
  output logic cap_en,
  output logic oe_q,
  output logic we_n_q
);
  import wl_pkg::*;

  logic e_prev;
  logic wr_cyc;
  logic wr_now;

  // E edges from successive synchronous samples
  always_ff @(posedge clk) begin
    if (rst) e_prev <= 1'b0;
    else     e_prev <= e_s;
  end

  assign rise_e = e_s & ~e_prev;
  assign fall_e = e_prev & ~e_s;
  assign wr_now = e_s & (rw_s == RW_WRITE);

  // remembers that this E-high phase carried a write, so the falling edge captures
  always_ff @(posedge clk) begin
    if (rst)         wr_cyc <= 1'b0;
    else if (wr_now) wr_cyc <= 1'b1;
    else if (fall_e) wr_cyc <= 1'b0;
  end

  // transparent while writing with E high, frozen after the falling-edge sample
  assign cap_en = wr_now | (fall_e & wr_cyc);

  // hold state: forced on by a write, cleared only by an E rise once R/W is high
  always_ff @(posedge clk) begin
    if (rst)                   oe_q <= 1'b0;
    else if (rw_s == RW_WRITE) oe_q <= 1'b1;
    else if (rise_e)           oe_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) we_n_q <= 1'b1;
    else     we_n_q <= ~wr_now;
  end
endmodule

// File: rtl/wl_latch.sv
module wl_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] d_s,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (cap_en) q <= d_s;
  end
endmodule

// File: rtl/bus_wr_latch.sv
module bus_wr_latch #(
  parameter int DATA_W = 8,
  parameter int IN_STAGES = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              e_in,
  input  logic              rw_n,
  input  logic [DATA_W-1:0] cpu_data,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_oe,
  output logic              ram_we_n
);
  import wl_pkg::*;

  localparam int SYNC_W = DATA_W + $bits(wl_ctl_t);
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, RW_READ, {DATA_W{1'b0}}};

  wl_ctl_t           ctl_s;
  logic [DATA_W-1:0] data_s;
  logic              e_s;
  logic              rw_s;
  logic              rise_e;
  logic              fall_e;
  logic              cap_en;

  wl_in_sync #(
    .W(SYNC_W),
    .STAGES(IN_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({e_in, rw_n, cpu_data}),
    .q_out({ctl_s, data_s})
  );

  assign e_s  = ctl_s.e;
  assign rw_s = ctl_s.rw_n;

  wl_seq u_seq (
    .clk   (clk),
    .rst   (rst),
    .e_s   (e_s),
    .rw_s  (rw_s),
    .rise_e(rise_e),
    .fall_e(fall_e),
    .cap_en(cap_en),
    .oe_q  (bus_oe),
    .we_n_q(ram_we_n)
  );

  wl_latch #(.W(DATA_W)) u_latch (
    .clk   (clk),
    .rst   (rst),
    .cap_en(cap_en),
    .d_s   (data_s),
    .q     (bus_data)
  );
endmodule

// File: rtl/bus_wr_latch_chk.sv
module bus_wr_latch_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              e_s,
  input logic              rw_s,
  input logic              rise_e,
  input logic              cap_en,
  input logic              bus_oe,
  input logic [DATA_W-1:0] bus_data,
  input logic              ram_we_n
);
  // R3: strobe low only following a sampled write level
  assert_we_only_write_R3: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> $past(!rw_s));

  // R2: strobe falls only after E was seen high
  assert_we_after_e_high_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(ram_we_n) |-> $past(e_s));

  // R5: a sampled write level drives the bus on the next cycle
  assert_drive_on_write_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!rw_s) |-> bus_oe);

  // R6: release happens only on an E rising edge
  assert_release_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_oe) |-> $past(rise_e));

  // R7: held byte is stable while driving and not capturing
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_oe && $past(bus_oe) && !$past(cap_en)) |-> $stable(bus_data));

  // R3: reads leave an idle bus idle
  assert_read_idle_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(rw_s) && !$past(bus_oe)) |-> !bus_oe);
endmodule

bind bus_wr_latch bus_wr_latch_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .e_s     (e_s),
  .rw_s    (rw_s),
  .rise_e  (rise_e),
  .cap_en  (cap_en),
  .bus_oe  (bus_oe),
  .bus_data(bus_data),
  .ram_we_n(ram_we_n)
);

// File: tb/bus_wr_latch_bench.sv
module bus_wr_latch_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          e_in = 1'b0;
  logic          rw_n = 1'b1;
  logic [DW-1:0] cpu_data = '0;
  logic [DW-1:0] bus_data;
  logic          bus_oe;
  logic          ram_we_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_wr_latch #(.DATA_W(DW), .IN_STAGES(1)) u_bus_wr_latch (
    .clk(clk), .rst(rst), .e_in(e_in), .rw_n(rw_n), .cpu_data(cpu_data),
    .bus_data(bus_data), .bus_oe(bus_oe), .ram_we_n(ram_we_n)
  );

  function automatic logic exp_we_n(input logic e, input logic rw);
    return !(e && !rw);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // lo >= 3, hi >= 2
  task automatic write_cycle(input logic [DW-1:0] d, input int lo, input int hi);
    logic [DW-1:0] junk;
    e_in = 1'b0; rw_n = 1'b0; cpu_data = d;
    tick(lo);
    chk(bus_oe == 1'b1, "R5 drive on write", bus_oe, 1);
    e_in = 1'b1;
    tick(hi);
    chk(ram_we_n == exp_we_n(1'b1, 1'b0), "R2 strobe low", ram_we_n, 0);
    e_in = 1'b0; rw_n = 1'b1;
    tick(1);
    junk = d ^ DW'($urandom_range(1, 255));
    cpu_data = junk;
    tick(1);
    chk(ram_we_n == exp_we_n(1'b0, 1'b1), "R2 strobe high after fall", ram_we_n, 1);
    chk(bus_data == d, "R4 captured byte", bus_data, d);
    chk(bus_oe == 1'b1, "R6 hold after rw high", bus_oe, 1);
    tick(lo - 2);
    chk(bus_data == d, "R7 junk ignored", bus_data, d);
    e_in = 1'b1;
    tick(1);
    chk(bus_oe == 1'b1, "R6 still driving", bus_oe, 1);
    tick(1);
    chk(bus_oe == 1'b0, "R6 released", bus_oe, 0);
    tick(hi - 2);
  endtask

  task automatic read_cycle(input int lo, input int hi);
    e_in = 1'b0; rw_n = 1'b1; cpu_data = DW'($urandom);
    for (int i = 0; i < lo; i++) begin
      tick(1);
      chk(bus_oe == 1'b0, "R3 no drive on read", bus_oe, 0);
      chk(ram_we_n == 1'b1, "R3 no strobe on read", ram_we_n, 1);
    end
    e_in = 1'b1;
    for (int i = 0; i < hi; i++) begin
      tick(1);
      chk(bus_oe == 1'b0, "R3 no drive on read", bus_oe, 0);
      chk(ram_we_n == exp_we_n(1'b1, 1'b1), "R3 no strobe on read", ram_we_n, 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2445));
    rst = 1'b1;
    tick(3);
    chk(bus_oe == 1'b0, "R1 reset oe", bus_oe, 0);
    chk(ram_we_n == 1'b1, "R1 reset strobe", ram_we_n, 1);
    chk(bus_data == '0, "R1 reset data", bus_data, 0);
    rst = 1'b0;
    e_in = 1'b1;
    tick(4);
    chk(bus_oe == 1'b0, "R1 idle after reset", bus_oe, 0);
    // directed corners: shortest phases, extreme bytes
    write_cycle(8'hFF, 3, 2);
    write_cycle(8'h00, 3, 2);
    read_cycle(3, 2);
    write_cycle(8'hA5, 6, 6);
    // random mix
    for (int k = 0; k < 60; k++) begin
      int lo = $urandom_range(3, 7);
      int hi = $urandom_range(2, 6);
      if ($urandom_range(0, 2) == 0) read_cycle(lo, hi);
      else write_cycle(DW'($urandom), lo, hi);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule